// File: doc/BRIEF.md
# Packet FIFO with write rollback

This block moves whole packets of 18-bit words from a producer clock domain to a consumer clock domain. The producer pushes words with a valid/ready handshake. Three control strobes frame that stream. `mark` commits everything written so far. `rollback` throws away every word written since the last commit. `pkt_done` commits the words and also counts one finished packet. The consumer reads words with a second valid/ready handshake. A separate flag tells it that at least one finished packet is waiting, and it lowers that count with `pkt_ack` once it has handled a packet.

Only committed words are visible to the reader. The committed write pointer crosses to the read domain in Gray code through two flops, and the read pointer comes back the same way. Packet-finished events cross as a toggle. The writer sees `full` and `almost_full`. Back-pressure rules are as follows. A word moves on the write side only in a cycle with `wr_valid` and `wr_ready` high. A word moves on the read side only in a cycle with `rd_valid` and `rd_ready` high. `rd_data` shows the head word, combinationally, while `rd_valid` is high. Operating rules: the write clock must not be faster than the read clock. `rrst` must either overlap `wrst` or stay high until at least two read clocks after it.

Top module: `pkt_rollback_fifo`

## Requirements
- R1: While the resets are held and right after them, `rd_valid`, `pkt_avail`, `full` and `almost_full` are 0 and `wr_ready` is 1.
- R2: Committed words reach `rd_data` in write order. A word is consumed in a read cycle with `rd_valid` and `rd_ready` high.
- R3: Words written after the last commit (`mark` or `pkt_done`) never make `rd_valid` rise.
- R4: `rollback` drops every word written since the last commit. In its cycle it takes priority over a same-cycle write, `mark` or `pkt_done`, so those have no effect.
- R5: Words committed by `mark` survive a later `rollback`.
- R6: Each `pkt_done` raises the completed-packet count by one, and each `pkt_ack` lowers it by one. `pkt_avail` is 1 exactly while the count is nonzero.
- R7: A `pkt_ack` while the count is zero is ignored. The count does not wrap.
- R8: `full` is 1 when the write-side occupancy (live write pointer minus synchronized read pointer) equals the depth. `wr_ready` is the inverse of `full`, and a write while full stores nothing.
- R9: `almost_full` is 1 when the write-side occupancy is at least the depth minus `AF_GAP`.
- R10: A read request while `rd_valid` is 0 leaves the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Write-domain synchronous reset, active high |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Room for a word (not full) |
| wr_data | input | DATA_W | Write word |
| mark | input | 1 | Commit the words written so far |
| rollback | input | 1 | Drop the words written since the last commit |
| pkt_done | input | 1 | Commit the words and count one finished packet |
| full | output | 1 | Write-side occupancy equals depth |
| almost_full | output | 1 | Write-side occupancy at or above depth minus AF_GAP |
| rclk | input | 1 | Read-domain clock |
| rrst | input | 1 | Read-domain synchronous reset, active high |
| rd_valid | output | 1 | A committed word is at the head |
| rd_ready | input | 1 | Consume the head word |
| rd_data | output | DATA_W | Head word |
| pkt_avail | output | 1 | At least one finished packet is counted |
| pkt_ack | input | 1 | One packet handled; lower the count |

## Verification
The bench builds the FIFO with `ADDR_W` = 4, giving 16 entries, and `AF_GAP` = 2. With that depth, both the `almost_full` threshold at 14 words and the `full` boundary at 16 can be reached in a few dozen cycles. A dropped seventeenth write is visible as data corruption or as a wrong word count. Both clock ports are driven from one 200 MHz clock, which meets the write-not-faster rule, while the Gray and toggle synchronizers keep their full latency.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
  localparam int unsigned WORD_W_DEF = 18;
  localparam int unsigned ADDR_W_DEF = 10;
  localparam int unsigned AF_GAP_DEF = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pkf_gray_sync.sv
module pkf_gray_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/pkf_write_ctl.sv
module pkf_write_ctl #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned AF_GAP = 2,
  localparam int unsigned PW = ADDR_W + 1,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              mark,
  input  logic              rollback,
  input  logic              pkt_done,
  input  logic [PW-1:0]     rptr_bin,
  output logic              wr_ready,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     cptr_gray,
  output logic              done_tgl,
  output logic              full,
  output logic              almost_full
);
  logic [PW-1:0] wptr, cptr, wptr_nx, used;

  assign used        = wptr - rptr_bin;
  assign full        = (used == PW'(DEPTH));
  assign almost_full = (used >= PW'(DEPTH - AF_GAP));
  assign wr_ready    = !full;
  assign we          = wr_valid && !full && !rollback;
  assign waddr       = wptr[ADDR_W-1:0];
  assign wptr_nx     = wptr + PW'(we);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      cptr      <= '0;
      cptr_gray <= '0;
      done_tgl  <= 1'b0;
    end else if (rollback) begin
      wptr <= cptr;
    end else begin
      wptr <= wptr_nx;
      if (mark || pkt_done) begin
        cptr      <= wptr_nx;
        cptr_gray <= wptr_nx ^ (wptr_nx >> 1);
      end
      if (pkt_done) done_tgl <= ~done_tgl;
    end
  end

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full && !rollback |=> wptr == $past(wptr));
  // R9
  af_covers_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);
  // R4
  rollback_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rollback |=> wptr == $past(cptr));
endmodule

// File: rtl/pkf_read_ctl.sv
module pkf_read_ctl #(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned PW = ADDR_W + 1,
  localparam int unsigned CW = ADDR_W + 1,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ready,
  input  logic [PW-1:0]     cptr_gray_async,
  input  logic              done_tgl_async,
  input  logic              pkt_ack,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rptr_gray,
  output logic              pkt_avail
);
  logic [PW-1:0] rptr, rptr_nx, cbin;
  logic [2:0]    tq;
  logic          evt, ack_ok, pop;
  logic [CW-1:0] cnt;

  pkf_gray_sync #(.W(PW)) u_csync (
    .clk(clk), .rst(rst), .gray_in(cptr_gray_async), .bin_out(cbin)
  );

  assign rd_valid  = (rptr != cbin);
  assign pop       = rd_ready && rd_valid;
  assign rptr_nx   = rptr + PW'(pop);
  assign raddr     = rptr[ADDR_W-1:0];
  assign evt       = tq[1] ^ tq[2];
  assign pkt_avail = (cnt != '0);
  assign ack_ok    = pkt_ack && pkt_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      tq        <= '0;
      cnt       <= '0;
    end else begin
      rptr      <= rptr_nx;
      rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
      tq        <= {tq[1:0], done_tgl_async};
      if (evt && !ack_ok && cnt != '1) cnt <= cnt + 1'b1;
      else if (!evt && ack_ok)         cnt <= cnt - 1'b1;
    end
  end

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid && rd_ready |=> rptr == $past(rptr));
  // R7
  ack_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_avail && pkt_ack && !evt |=> !pkt_avail);
  // R3
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    (cbin - rptr) <= PW'(DEPTH));
endmodule

// File: rtl/pkt_rollback_fifo.sv
module pkt_rollback_fifo #(
  parameter int unsigned DATA_W = pkf_pkg::WORD_W_DEF,
  parameter int unsigned ADDR_W = pkf_pkg::ADDR_W_DEF,
  parameter int unsigned AF_GAP = pkf_pkg::AF_GAP_DEF
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mark,
  input  logic              rollback,
  input  logic              pkt_done,
  output logic              full,
  output logic              almost_full,
  input  logic              rclk,
  input  logic              rrst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              pkt_avail,
  input  logic              pkt_ack
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we, done_tgl;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     cptr_gray, rptr_gray, rptr_wsync;

  pkf_write_ctl #(.ADDR_W(ADDR_W), .AF_GAP(AF_GAP)) u_wctl (
    .clk(wclk), .rst(wrst), .wr_valid(wr_valid), .mark(mark),
    .rollback(rollback), .pkt_done(pkt_done), .rptr_bin(rptr_wsync),
    .wr_ready(wr_ready), .we(we), .waddr(waddr), .cptr_gray(cptr_gray),
    .done_tgl(done_tgl), .full(full), .almost_full(almost_full)
  );

  pkf_gray_sync #(.W(PW)) u_rsync (
    .clk(wclk), .rst(wrst), .gray_in(rptr_gray), .bin_out(rptr_wsync)
  );

  pkf_read_ctl #(.ADDR_W(ADDR_W)) u_rctl (
    .clk(rclk), .rst(rrst), .rd_ready(rd_ready),
    .cptr_gray_async(cptr_gray), .done_tgl_async(done_tgl),
    .pkt_ack(pkt_ack), .rd_valid(rd_valid), .raddr(raddr),
    .rptr_gray(rptr_gray), .pkt_avail(pkt_avail)
  );

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wr_data;
  end

  assign rd_data = mem[raddr];
endmodule

// File: tb/pkt_rollback_fifo_bench.sv
`timescale 1ns/1ps
module pkt_rollback_fifo_bench;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 0, mark = 0, rollback = 0, pkt_done = 0, pkt_ack = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, full, almost_full, rd_valid, pkt_avail;
  logic [DW-1:0] rd_data;
  logic mon_on = 0, force_rdy = 0, mon_rdy = 0, rd_ready;

  int total = 0, bad = 0, seen = 0;
  logic [DW-1:0] pend[$];
  logic [DW-1:0] expq[$];

  always #2.5 clk = ~clk;
  assign rd_ready = mon_rdy | force_rdy;

  pkt_rollback_fifo #(.DATA_W(DW), .ADDR_W(AW), .AF_GAP(GAP)) u_pkt_rollback_fifo (
    .wclk(clk), .wrst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .mark(mark), .rollback(rollback), .pkt_done(pkt_done),
    .full(full), .almost_full(almost_full), .rclk(clk), .rrst(rst),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .pkt_avail(pkt_avail), .pkt_ack(pkt_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compares the head word with the scoreboard, then consumes it
  always @(negedge clk) begin
    mon_rdy = 1'b0;
    if (mon_on && rd_valid) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R2 R3: actual=%0d expected=none (uncommitted word visible)", rd_data);
      end else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL R2: actual=%0d expected=%0d", rd_data, e);
        end
      end
      seen++;
      mon_rdy = 1'b1;
    end
  end

  task automatic wr(input logic [DW-1:0] d, input bit keep);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    if (keep) pend.push_back(d);
  endtask

  task automatic commit_pend();
    while (pend.size() > 0) expq.push_back(pend.pop_front());
  endtask

  task automatic do_mark();
    mark = 1; @(negedge clk); mark = 0; commit_pend();
  endtask

  task automatic do_done();
    pkt_done = 1; @(negedge clk); pkt_done = 0; commit_pend();
  endtask

  task automatic do_rollback();
    rollback = 1; @(negedge clk); rollback = 0; pend.delete();
  endtask

  task automatic do_ack();
    pkt_ack = 1; @(negedge clk); pkt_ack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    idle(5);
    // R1 reset state
    chk(!rd_valid && !pkt_avail && !full && !almost_full && wr_ready, "R1", {rd_valid, pkt_avail, full, almost_full}, 0);
    rst = 0;
    idle(2);
    chk(!rd_valid && !pkt_avail && wr_ready, "R1", {rd_valid, pkt_avail}, 0);

    // R2 / R6 basic packet
    mon_on = 1; s0 = seen;
    wr(18'h00011, 1); wr(18'h3ABCD, 1); wr(18'h20002, 1);
    do_done();
    idle(10);
    chk(seen - s0 == 3 && expq.size() == 0, "R2", seen - s0, 3);
    chk(pkt_avail, "R6", pkt_avail, 1);
    do_ack(); idle(1);
    chk(!pkt_avail, "R6", pkt_avail, 0);

    // R3 uncommitted invisible, R4 rollback
    s0 = seen;
    wr(18'h0BAD1, 1); wr(18'h0BAD2, 1);
    idle(8);
    chk(!rd_valid && seen == s0, "R3", rd_valid, 0);
    do_rollback();
    wr(18'h00555, 1); wr(18'h00666, 1);
    do_done();
    idle(10);
    chk(seen - s0 == 2 && expq.size() == 0, "R4", seen - s0, 2);
    do_ack();

    // R5 mark survives rollback
    s0 = seen;
    wr(18'h01010, 1); wr(18'h02020, 1);
    do_mark();
    wr(18'h0DEAD, 1); wr(18'h0BEEF, 1);
    do_rollback();
    do_done();
    idle(10);
    chk(seen - s0 == 2 && expq.size() == 0, "R5", seen - s0, 2);
    do_ack(); idle(1);

    // R7 ack at zero ignored, R6 counting
    chk(!pkt_avail, "R7", pkt_avail, 0);
    do_ack(); do_ack(); do_ack();
    idle(2);
    chk(!pkt_avail, "R7", pkt_avail, 0);
    do_done(); do_done();
    idle(5);
    chk(pkt_avail, "R6", pkt_avail, 1);
    do_ack(); idle(1);
    chk(pkt_avail, "R7", pkt_avail, 1);
    do_ack(); idle(1);
    chk(!pkt_avail, "R6", pkt_avail, 0);

    // R8 / R9 full and almost full
    mon_on = 0; idle(2); s0 = seen;
    for (int i = 0; i < 13; i++) wr(18'(i + 100), 1);
    chk(!almost_full, "R9", almost_full, 0);
    wr(18'd113, 1);
    chk(almost_full && !full, "R9", {almost_full, full}, 2);
    wr(18'd114, 1); wr(18'd115, 1);
    chk(full && !wr_ready, "R8", {full, wr_ready}, 2);
    wr(18'h3FFFF, 0);
    do_done();
    mon_on = 1;
    idle(30);
    chk(seen - s0 == 16 && expq.size() == 0, "R8", seen - s0, 16);
    chk(!full && !almost_full, "R8", {full, almost_full}, 0);
    do_ack();

    // R10 read request while empty
    mon_on = 0; idle(2);
    force_rdy = 1; idle(5); force_rdy = 0;
    chk(!rd_valid, "R10", rd_valid, 0);
    mon_on = 1; s0 = seen;
    wr(18'h12345, 1); wr(18'h23456, 1);
    do_done();
    idle(10);
    chk(seen - s0 == 2 && expq.size() == 0, "R10", seen - s0, 2);
    do_ack();

    // R4 rollback beats a same-cycle write
    s0 = seen;
    wr_valid = 1; wr_data = 18'h0F00F; rollback = 1;
    @(negedge clk);
    wr_valid = 0; rollback = 0; pend.delete();
    do_done();
    idle(10);
    chk(seen == s0 && !rd_valid, "R4", seen - s0, 0);
    do_ack(); idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule